// File: doc/BRIEF.md
# Serial Register Control Interface

This block gives a host processor access to a small bank of 16-bit configuration registers over a three-wire serial link made of a serial clock, an active-low chip select and a data input, plus a serial data output for readback. Every serial pin is synchronised into the block's system clock. Edges of the serial clock and the chip select are then detected in that clock domain. The registers are presented to the rest of the chip as one flat parallel output bus.

A frame starts when chip select falls. It carries a 7-bit register address, then a direction flag, then 16-bit data words, each sent most-significant bit first. Write data is held in a pending buffer and is committed when chip select rises. When auto-increment is enabled in the control register, further words in the same frame go to consecutive addresses. This applies to reads as well as writes. Two read-only identification registers sit at the bottom of the address map. A write of any value to address 00h returns every writable register to its default. A mode-select input is synchronised and reported. While it selects the two-wire protocol, which this block does not implement, the three-wire engine ignores new frames.

The frame state machine has five states:

- Idle: waiting for chip select to fall.
- Header: shifting in the address and the direction flag.
- Write-data: shifting in write words.
- Read-data: shifting out read words.
- Hold: ignoring further clocks until chip select rises.

It has the following transitions:

- Idle to Header: chip select falls while the three-wire protocol is selected.
- Header to Write-data: the eighth rising edge carries a direction flag of 0.
- Header to Read-data: the eighth rising edge carries a direction flag of 1.
- Write-data to Hold, and Read-data to Hold: a word completes while auto-increment is off.
- Any state other than Idle back to Idle: chip select rises.

Top module: `cfg_serial_regs`

## Requirements
- R1: After reset, the writable register at address 02h+k holds 0000h for k=0 and 5A00h+k for k from 1 to 7. `reg_out` carries register k at bits [16k+15:16k]. `ser_dout` and `proto_2wire` are 0.
- R2: A frame sends the address (7 bits), then a direction bit (0 = write, 1 = read), then 16-bit words, all MSB first. `ser_din` is sampled on the rising edge of `ser_clk`. A write word lands in the addressed register.
- R3: A write changes `reg_out` only after `ser_cs_n` rises. Before that rise, the register keeps its old value even though the whole word has arrived.
- R4: In a read, `ser_dout` shows data bit 15 after the first falling `ser_clk` edge that follows the direction bit. Each lower bit follows on the next falling edge. Outside the read data phase `ser_dout` is 0.
- R5: Reading address 00h returns the identifier C3A5h. Reading address 01h returns the revision 0004h. Writes to 01h have no effect.
- R6: A write of any data to address 00h returns all writable registers to their R1 defaults.
- R7: If `ser_cs_n` rises before 16 data bits of a word have arrived, that partial word is discarded and no register changes.
- R8: When bit 0 of register 02h is 1, each further 16-bit write word in the frame goes to the next address. When that bit is 0, words after the first are ignored.
- R9: When bit 0 of register 02h is 1, each further read word in the frame returns the next address.
- R10: Addresses 0Ah to 7Fh read as 0000h, and writes to them are ignored.
- R11: `proto_2wire` follows `mode_sel` after synchronisation (1 = two-wire selected). A frame that starts while it is 1 writes nothing and leaves `ser_dout` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Protocol select, 1 = two-wire |
| ser_clk | input | 1 | Serial clock from host |
| ser_cs_n | input | 1 | Serial chip select, active low |
| ser_din | input | 1 | Serial data from host |
| ser_dout | output | 1 | Serial readback data |
| proto_2wire | output | 1 | Synchronised protocol select |
| reg_out | output | 128 | Writable registers, register k at [16k+15:16k] |

## Verification
Two of the block's functions can fall in the same cycle in an auto-increment transfer. When a word completes, the previous pending write is committed at the same edge that captures the new word and advances the address. In a read, the next address's data is reloaded at the same edge that samples the last bit of the previous word. Three-word write and read frames provoke both overlaps. They are judged by checking that every word lands in, and returns from, consecutive registers in order, with the neighbouring registers untouched.

// File: rtl/csr_pkg.sv
`timescale 1ns/1ps
package csr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_WDATA,
        ST_RDATA,
        ST_HOLD
    } fr_state_e;

    // Reset value of writable slot k: slot 0 (control) clears, others carry hi byte and index.
    function automatic logic [31:0] slot_default(input int unsigned slot, input logic [7:0] hi);
        if (slot == 0) begin
            return 32'h0;
        end
        return {16'h0, hi, 8'(slot)};
    endfunction

endpackage

// File: rtl/csr_sync.sv
`timescale 1ns/1ps
module csr_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= RST_VAL;
            end
        end else begin
            chain_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/csr_frame_fsm.sv
`timescale 1ns/1ps
module csr_frame_fsm
    import csr_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              din,
    input  logic              two_wire,
    input  logic              autoinc,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              dout,
    output fr_state_e         state
);

    localparam int HEAD_BITS = ADDR_W + 1;
    localparam int CNT_W     = $clog2(HEAD_BITS + DATA_W);
    localparam logic [CNT_W-1:0] LAST_HEAD = CNT_W'(HEAD_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);

    fr_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] head_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-2:0] wsr_q;
    logic [DATA_W-1:0] rsr_q;
    logic              pend_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic [DATA_W-1:0] pend_data_q;
    logic              dout_q;

    logic              head_last;
    logic              word_last;
    logic [DATA_W-1:0] word_in;
    logic [ADDR_W-1:0] addr_next;

    assign head_last = (state_q == ST_HEAD) && sclk_rise && (cnt_q == LAST_HEAD);
    assign word_last = ((state_q == ST_WDATA) || (state_q == ST_RDATA))
                       && sclk_rise && (cnt_q == LAST_DATA);
    assign word_in   = {wsr_q, din};
    assign addr_next = addr_q + 1'b1;
    assign rd_addr   = (state_q == ST_HEAD) ? head_q : addr_next;
    assign dout      = dout_q;
    assign state     = state_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if ((state_q != ST_IDLE) && cs_rise) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (cs_fall && !two_wire) state_d = ST_HEAD;
                ST_HEAD:  if (head_last) state_d = din ? ST_RDATA : ST_WDATA;
                ST_WDATA,
                ST_RDATA: if (word_last && !autoinc) state_d = ST_HOLD;
                ST_HOLD:  state_d = ST_HOLD;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            head_q      <= '0;
            addr_q      <= '0;
            wsr_q       <= '0;
            rsr_q       <= '0;
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
            pend_data_q <= '0;
            dout_q      <= 1'b0;
            wr_en       <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
        end else begin
            wr_en <= 1'b0;
            if (state_q == ST_IDLE) begin
                cnt_q  <= '0;
                dout_q <= 1'b0;
            end
            if ((state_q != ST_IDLE) && cs_rise) begin
                if (pend_q) begin
                    wr_en   <= 1'b1;
                    wr_addr <= pend_addr_q;
                    wr_data <= pend_data_q;
                end
                pend_q <= 1'b0;
                dout_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                if ((state_q == ST_HEAD) && sclk_rise) begin
                    head_q <= {head_q[ADDR_W-2:0], din};
                    cnt_q  <= head_last ? '0 : cnt_q + 1'b1;
                    if (head_last) begin
                        addr_q <= head_q;
                        rsr_q  <= rd_data;
                    end
                end
                if ((state_q == ST_WDATA) && sclk_rise) begin
                    wsr_q <= word_in[DATA_W-2:0];
                    cnt_q <= word_last ? '0 : cnt_q + 1'b1;
                    if (word_last) begin
                        if (pend_q) begin
                            wr_en   <= 1'b1;
                            wr_addr <= pend_addr_q;
                            wr_data <= pend_data_q;
                        end
                        pend_q      <= 1'b1;
                        pend_addr_q <= addr_q;
                        pend_data_q <= word_in;
                        addr_q      <= addr_next;
                    end
                end
                if (state_q == ST_RDATA) begin
                    if (sclk_fall) begin
                        dout_q <= rsr_q[DATA_W-1];
                        rsr_q  <= rsr_q << 1;
                    end
                    if (sclk_rise) begin
                        cnt_q <= word_last ? '0 : cnt_q + 1'b1;
                        if (word_last) begin
                            addr_q <= addr_next;
                            rsr_q  <= rd_data;
                        end
                    end
                end
                if ((state_q == ST_HOLD) && sclk_fall) begin
                    dout_q <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/csr_reg_bank.sv
`timescale 1ns/1ps
module csr_reg_bank
    import csr_pkg::*;
#(
    parameter int              ADDR_W = 7,
    parameter int              DATA_W = 16,
    parameter int              NUM_RW = 8,
    parameter int              BASE   = 2,
    parameter logic [DATA_W-1:0] DEV_ID = 16'hC3A5,
    parameter logic [DATA_W-1:0] REV_ID = 16'h0004,
    parameter logic [7:0]      DEF_HI = 8'h5A
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     autoinc,
    output logic [NUM_RW*DATA_W-1:0] regs_flat
);

    localparam int LAST = BASE + NUM_RW - 1;

    for (genvar k = 0; k < NUM_RW; k++) begin : g_slot
        localparam logic [DATA_W-1:0] DEF     = DATA_W'(slot_default(k, DEF_HI));
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE + k);
        logic [DATA_W-1:0] slot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= DEF;
            end else if (wr_en) begin
                if (wr_addr == '0) begin
                    slot_q <= DEF;
                end else if (wr_addr == MY_ADDR) begin
                    slot_q <= wr_data;
                end
            end
        end

        assign regs_flat[k*DATA_W +: DATA_W] = slot_q;
    end

    int ridx;
    always_comb begin
        ridx    = int'(rd_addr) - BASE;
        rd_data = '0;
        if (rd_addr == ADDR_W'(0)) begin
            rd_data = DEV_ID;
        end else if (rd_addr == ADDR_W'(1)) begin
            rd_data = REV_ID;
        end else if ((int'(rd_addr) >= BASE) && (int'(rd_addr) <= LAST)) begin
            rd_data = regs_flat[ridx*DATA_W +: DATA_W];
        end
    end

    assign autoinc = regs_flat[0];

endmodule

// File: rtl/cfg_serial_regs.sv
`timescale 1ns/1ps
module cfg_serial_regs
    import csr_pkg::*;
#(
    parameter int              ADDR_W      = 7,
    parameter int              DATA_W      = 16,
    parameter int              NUM_RW      = 8,
    parameter int              BASE        = 2,
    parameter int              SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] DEV_ID    = 16'hC3A5,
    parameter logic [DATA_W-1:0] REV_ID    = 16'h0004,
    parameter logic [7:0]      DEF_HI      = 8'h5A
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_sel,
    input  logic                     ser_clk,
    input  logic                     ser_cs_n,
    input  logic                     ser_din,
    output logic                     ser_dout,
    output logic                     proto_2wire,
    output logic [NUM_RW*DATA_W-1:0] reg_out
);

    // Synchronised pins: bit0 serial clock, bit1 chip select, bit2 data, bit3 mode.
    logic [3:0]        pins_s;
    logic [1:0]        edge_prev_q;
    logic              sclk_rise, sclk_fall, cs_fall, cs_rise;
    logic              autoinc;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    fr_state_e         fsm_state;

    csr_sync #(
        .WIDTH   (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b0010)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({mode_sel, ser_din, ser_cs_n, ser_clk}),
        .sync_out (pins_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_prev_q <= 2'b10;
        end else begin
            edge_prev_q <= pins_s[1:0];
        end
    end

    assign sclk_rise   =  pins_s[0] && !edge_prev_q[0];
    assign sclk_fall   = !pins_s[0] &&  edge_prev_q[0];
    assign cs_fall     = !pins_s[1] &&  edge_prev_q[1];
    assign cs_rise     =  pins_s[1] && !edge_prev_q[1];
    assign proto_2wire =  pins_s[3];

    csr_frame_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .din       (pins_s[2]),
        .two_wire  (pins_s[3]),
        .autoinc   (autoinc),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .dout      (ser_dout),
        .state     (fsm_state)
    );

    csr_reg_bank #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NUM_RW (NUM_RW),
        .BASE   (BASE),
        .DEV_ID (DEV_ID),
        .REV_ID (REV_ID),
        .DEF_HI (DEF_HI)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .autoinc   (autoinc),
        .regs_flat (reg_out)
    );

endmodule

// File: rtl/cfg_serial_regs_chk.sv
`timescale 1ns/1ps
module cfg_serial_regs_chk
    import csr_pkg::*;
#(
    parameter int         ADDR_W = 7,
    parameter int         DATA_W = 16,
    parameter int         NUM_RW = 8,
    parameter int         BASE   = 2,
    parameter logic [7:0] DEF_HI = 8'h5A
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  fr_state_e                fsm_state,
    input  logic                     ser_dout,
    input  logic                     proto_2wire,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [NUM_RW*DATA_W-1:0] reg_out
);

    function automatic logic [NUM_RW*DATA_W-1:0] all_defaults();
        logic [NUM_RW*DATA_W-1:0] v;
        for (int k = 0; k < NUM_RW; k++) begin
            v[k*DATA_W +: DATA_W] = DATA_W'(slot_default(k, DEF_HI));
        end
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] get_slot(input logic [NUM_RW*DATA_W-1:0] v, input int idx);
        return v[idx*DATA_W +: DATA_W];
    endfunction

    localparam logic [NUM_RW*DATA_W-1:0] DEFS = all_defaults();

    int   wr_idx;
    logic mapped;
    assign wr_idx = int'(wr_addr) - BASE;
    assign mapped = (wr_idx >= 0) && (wr_idx < NUM_RW);

    // R4: no readback data outside the read data phase
    p_dout_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state inside {ST_IDLE, ST_HEAD, ST_WDATA}) |-> !ser_dout);

    // R3: the register outputs move only after a commit pulse
    p_change_needs_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_out) |-> $past(wr_en));

    // R2: a committed word lands in its slot
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mapped) |=> (get_slot(reg_out, $past(wr_idx)) == $past(wr_data)));

    // R6: a commit to address zero restores defaults
    p_soft_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == '0)) |=> (reg_out == DEFS));

    // R5: revision address is read-only
    p_rev_readonly_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == ADDR_W'(1))) |=> $stable(reg_out));

    // R10: unmapped addresses ignore writes
    p_unmapped_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mapped && (int'(wr_addr) > 1)) |=> $stable(reg_out));

    // R11: no frame starts while the two-wire protocol is selected
    p_mode_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_state == ST_IDLE) && proto_2wire) |=> (fsm_state == ST_IDLE));

endmodule

bind cfg_serial_regs cfg_serial_regs_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_RW (NUM_RW),
    .BASE   (BASE),
    .DEF_HI (DEF_HI)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fsm_state   (fsm_state),
    .ser_dout    (ser_dout),
    .proto_2wire (proto_2wire),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .reg_out     (reg_out)
);

// File: tb/cfg_serial_regs_test.sv
`timescale 1ns/1ps
module cfg_serial_regs_test;

    localparam int NRW  = 8;
    localparam int DW   = 16;
    localparam int BASE = 2;
    localparam int HALF = 8;
    localparam int NVEC = 13;

    // {direction, address, data}; direction 1 = read
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b0, 7'h03, 16'h1234},
        {1'b1, 7'h03, 16'h0000},
        {1'b0, 7'h09, 16'hBEEF},
        {1'b1, 7'h09, 16'h0000},
        {1'b1, 7'h00, 16'h0000},
        {1'b1, 7'h01, 16'h0000},
        {1'b0, 7'h01, 16'hFFFF},
        {1'b1, 7'h01, 16'h0000},
        {1'b0, 7'h0A, 16'h5555},
        {1'b1, 7'h0A, 16'h0000},
        {1'b1, 7'h7F, 16'h0000},
        {1'b0, 7'h05, 16'hA5A5},
        {1'b1, 7'h04, 16'h0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_sel = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic din = 1'b0;
    logic dout;
    logic p2w;
    logic [NRW*DW-1:0] regs;

    int  n_chk = 0;
    int  n_err = 0;
    bit  finished = 1'b0;
    logic [15:0] mdl [NRW];

    always #2.5 clk = ~clk;

    cfg_serial_regs uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_sel    (mode_sel),
        .ser_clk     (sclk),
        .ser_cs_n    (cs_n),
        .ser_din     (din),
        .ser_dout    (dout),
        .proto_2wire (p2w),
        .reg_out     (regs)
    );

    task automatic check(input string tag, input logic [NRW*DW-1:0] act, input logic [NRW*DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic mdl_reset();
        for (int k = 0; k < NRW; k++) begin
            mdl[k] = (k == 0) ? 16'h0000 : (16'h5A00 | 16'(k));
        end
    endtask

    task automatic mdl_write(input logic [6:0] a, input logic [15:0] d);
        if (a == 7'h00) mdl_reset();
        else if ((int'(a) >= BASE) && (int'(a) < BASE + NRW)) mdl[int'(a) - BASE] = d;
    endtask

    function automatic logic [15:0] mdl_read(input logic [6:0] a);
        if (a == 7'h00) return 16'hC3A5;
        if (a == 7'h01) return 16'h0004;
        if ((int'(a) >= BASE) && (int'(a) < BASE + NRW)) return mdl[int'(a) - BASE];
        return 16'h0000;
    endfunction

    function automatic logic [NRW*DW-1:0] mdl_flat();
        logic [NRW*DW-1:0] v;
        for (int k = 0; k < NRW; k++) v[k*DW +: DW] = mdl[k];
        return v;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_begin();
        wait_clk(HALF);
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic frame_end();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic shift_bit(input logic b, output logic s);
        din = b;
        wait_clk(HALF);
        s = dout;
        sclk = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
    endtask

    task automatic send_head(input logic rw, input logic [6:0] a, output logic seen);
        logic s;
        seen = 1'b0;
        for (int i = 6; i >= 0; i--) begin
            shift_bit(a[i], s);
            seen |= s;
        end
        shift_bit(rw, s);
        seen |= s;
    endtask

    task automatic xfer_word(input logic [15:0] w, output logic [15:0] r);
        logic s;
        for (int i = 15; i >= 0; i--) begin
            shift_bit(w[i], s);
            r[i] = s;
        end
    endtask

    task automatic do_write(input logic [6:0] a, input logic [15:0] d);
        logic seen;
        logic [15:0] r;
        frame_begin();
        send_head(1'b0, a, seen);
        xfer_word(d, r);
        frame_end();
    endtask

    task automatic do_read(input logic [6:0] a, output logic [15:0] r, output logic seen);
        frame_begin();
        send_head(1'b1, a, seen);
        xfer_word(16'h0000, r);
        frame_end();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [15:0] r0, r1, r2;
        logic seen;
        mdl_reset();
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R1: reset state
        check("R1 defaults", regs, mdl_flat());
        check("R1 dout", NRW*DW'(dout), '0);
        check("R1 proto", NRW*DW'(p2w), '0);

        // R2 R5 R10: single-word vector table
        for (int i = 0; i < NVEC; i++) begin
            logic rw;
            logic [6:0] a;
            logic [15:0] d;
            {rw, a, d} = VEC[i];
            if (rw) begin
                do_read(a, r0, seen);
                check("R2/R5/R10 read value", NRW*DW'(r0), NRW*DW'(mdl_read(a)));
                check("R4 dout low in header", NRW*DW'(seen), '0);
            end else begin
                do_write(a, d);
                mdl_write(a, d);
                check("R2/R5/R10 write effect", regs, mdl_flat());
            end
        end
        check("R4 dout idle", NRW*DW'(dout), '0);

        // R3: no change before chip select rises
        frame_begin();
        send_head(1'b0, 7'h07, seen);
        xfer_word(16'h0F0F, r0);
        wait_clk(HALF);
        check("R3 before cs rise", regs, mdl_flat());
        frame_end();
        mdl_write(7'h07, 16'h0F0F);
        check("R3 after cs rise", regs, mdl_flat());

        // R7: partial word discarded
        frame_begin();
        send_head(1'b0, 7'h03, seen);
        for (int i = 0; i < 10; i++) shift_bit(1'b1, r0[0]);
        frame_end();
        check("R7 partial word", regs, mdl_flat());

        // R8: auto-increment write
        do_write(7'h02, 16'h0001);
        mdl_write(7'h02, 16'h0001);
        frame_begin();
        send_head(1'b0, 7'h04, seen);
        xfer_word(16'h1111, r0);
        xfer_word(16'h2222, r0);
        xfer_word(16'h3333, r0);
        frame_end();
        mdl_write(7'h04, 16'h1111);
        mdl_write(7'h05, 16'h2222);
        mdl_write(7'h06, 16'h3333);
        check("R8 autoinc write", regs, mdl_flat());

        // R9: auto-increment read
        frame_begin();
        send_head(1'b1, 7'h04, seen);
        xfer_word(16'h0000, r0);
        xfer_word(16'h0000, r1);
        xfer_word(16'h0000, r2);
        frame_end();
        check("R9 word0", NRW*DW'(r0), NRW*DW'(16'h1111));
        check("R9 word1", NRW*DW'(r1), NRW*DW'(16'h2222));
        check("R9 word2", NRW*DW'(r2), NRW*DW'(16'h3333));

        // R8: auto-increment off ignores extra words
        do_write(7'h02, 16'h0000);
        mdl_write(7'h02, 16'h0000);
        frame_begin();
        send_head(1'b0, 7'h07, seen);
        xfer_word(16'hAAAA, r0);
        xfer_word(16'hBBBB, r0);
        frame_end();
        mdl_write(7'h07, 16'hAAAA);
        check("R8 autoinc off", regs, mdl_flat());

        // R6: write to address zero restores defaults
        do_write(7'h00, 16'h9876);
        mdl_write(7'h00, 16'h9876);
        check("R6 soft reset", regs, mdl_flat());
        do_read(7'h02, r0, seen);
        check("R6 control default", NRW*DW'(r0), '0);

        // R11: two-wire selected blocks frames
        mode_sel = 1'b1;
        wait_clk(6);
        check("R11 proto high", NRW*DW'(p2w), NRW*DW'(1'b1));
        do_write(7'h03, 16'h7777);
        check("R11 write ignored", regs, mdl_flat());
        do_read(7'h00, r0, seen);
        check("R11 dout low", NRW*DW'(r0), '0);
        mode_sel = 1'b0;
        wait_clk(6);
        check("R11 proto low", NRW*DW'(p2w), '0);
        do_read(7'h00, r0, seen);
        check("R11 resume", NRW*DW'(r0), NRW*DW'(16'hC3A5));

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule